// File: doc/BRIEF.md
# Processor Sleep-State Sequencer

This block follows a processor package down and back up a ladder of nested low-power states. The ladder runs Stop-Grant, Sleep, Deep Sleep, Deeper Sleep, and an enhanced Deeper Sleep sub-state. Three active-low request pins move it between rungs. Each pin can only take the ladder one rung deeper from the rung directly above. A cache-off status flag decides which Deeper variant is entered. When the block climbs out of Deep Sleep, it holds an intermediate re-lock state. It counts a fixed settle time on a free-running reference clock and only then reports Sleep. The bus clock may have been stopped, so it is not used for this count.

From the current rung the block derives several outputs. It drives the 7-bit voltage identification code and a permission for the clock generator to halt the bus clock. It drives an enable that allows snoops to be answered and interrupts to be latched. It also reports whether the PLL is stable. A request pin may change in a way the ladder does not permit, for example a deeper request without the shallower one, or a shallower release while deeper ones are held. In that case the block keeps its state and raises a sticky protocol-error flag.

Top module: `sleep_ladder`

## Requirements
- R1: While reset is held and right after it, the state is Stop-Grant (code 0), `vid_o` equals `VID_NOM`, `snoop_en` and `pll_stable` are 1, and `clk_stop_ok` and `proto_err` are 0.
- R2: From Stop-Grant, asserting `sleep_n` low (with the other two high) moves the block to Sleep (code 1). From Sleep, releasing `sleep_n` with `deep_n` high moves it back to Stop-Grant.
- R3: Deep Sleep (code 2) is entered only from Sleep, when `deep_n` goes low while `sleep_n` is low and `deeper_n` is high. In Deep Sleep, `clk_stop_ok` is 1, and `snoop_en` and `pll_stable` are 0.
- R4: From Deep Sleep, `deeper_n` going low with `cache_off` = 0 enters Deeper Sleep (code 3), which drives `VID_DEEPER` on `vid_o`.
- R5: From Deep Sleep, `deeper_n` going low with `cache_off` = 1 enters the enhanced sub-state (code 4), which drives `VID_ENH`. Once either Deeper variant is entered, later changes of `cache_off` do not change the state or the code.
- R6: From either Deeper variant, releasing `deeper_n` (with the other two still low) returns to Deep Sleep, and `vid_o` returns to `VID_NOM`.
- R7: From Deep Sleep, releasing `deep_n` (with `sleep_n` low and `deeper_n` high) enters the re-lock state (code 5). The block stays there for exactly `CYC_PER_US*SETTLE_US` clocks and then reports Sleep. `pll_stable`, `snoop_en` and `clk_stop_ok` are all 0 while it is in re-lock.
- R8: Any other input combination is a violation. Examples are `deep_n` or `deeper_n` low in Stop-Grant, `deeper_n` low in Sleep, `sleep_n` released below Sleep, `deep_n` released while `deeper_n` is low, and any change while in re-lock. On a violation the state is held and `proto_err` goes to 1, where it stays until reset.
- R9: `snoop_en` is 1 only in Stop-Grant and Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low Sleep request |
| deep_n | input | 1 | Active-low Deep Sleep request |
| deeper_n | input | 1 | Active-low Deeper Sleep request |
| cache_off | input | 1 | 1 when the second-level cache is fully powered down |
| state_o | output | 3 | Current state code (0..5) |
| vid_o | output | 7 | Voltage identification code |
| clk_stop_ok | output | 1 | Bus clock may be halted |
| snoop_en | output | 1 | Snoops answered and interrupts latched |
| pll_stable | output | 1 | PLL considered locked |
| proto_err | output | 1 | Sticky request-protocol violation |

## Verification
The hardest situations to reach are the violations raised from the deeper rungs and from the timed re-lock state. Reaching them needs a legal walk down the ladder first, and then a bad input vector applied at exactly the right moment. The bench resets the block and walks it to each rung in turn. On each rung it applies every one of the eight request vectors, and for Deep Sleep it also tries both cache flag values. It then compares the resulting state and error flag against a table built from the ladder rules. The re-lock window is measured by counting clocks from the release of `deep_n` until Sleep appears.

// File: rtl/sleep_ladder.sv
module sleep_ladder #(
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 15,
  parameter logic [6:0] VID_NOM    = 7'h30,
  parameter logic [6:0] VID_DEEPER = 7'h3A,
  parameter logic [6:0] VID_ENH    = 7'h42
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       deep_n,
  input  logic       deeper_n,
  input  logic       cache_off,
  output logic [2:0] state_o,
  output logic [6:0] vid_o,
  output logic       clk_stop_ok,
  output logic       snoop_en,
  output logic       pll_stable,
  output logic       proto_err
);
  localparam logic [2:0] S_GRANT  = 3'd0;
  localparam logic [2:0] S_SLEEP  = 3'd1;
  localparam logic [2:0] S_DEEP   = 3'd2;
  localparam logic [2:0] S_DEEPER = 3'd3;
  localparam logic [2:0] S_ENH    = 3'd4;
  localparam logic [2:0] S_RELOCK = 3'd5;
  localparam int LIMIT = CYC_PER_US * SETTLE_US;
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [2:0]    st, nxt;
  logic [CW-1:0] cnt;
  logic          viol;

  wire sl = ~sleep_n;
  wire dp = ~deep_n;
  wire dr = ~deeper_n;
  wire done = (cnt == LAST);

  always_comb begin
    nxt  = st;
    viol = 1'b0;
    case (st)
      S_GRANT:
        if (dp || dr)                 viol = 1'b1;
        else if (sl)                  nxt  = S_SLEEP;
      S_SLEEP:
        if (dr || (dp && !sl))        viol = 1'b1;
        else if (!sl)                 nxt  = S_GRANT;
        else if (dp)                  nxt  = S_DEEP;
      S_DEEP:
        if (!sl || (dr && !dp))       viol = 1'b1;
        else if (!dp)                 nxt  = S_RELOCK;
        else if (dr)                  nxt  = cache_off ? S_ENH : S_DEEPER;
      S_DEEPER, S_ENH:
        if (!sl || !dp)               viol = 1'b1;
        else if (!dr)                 nxt  = S_DEEP;
      S_RELOCK:
        if (!sl || dp || dr)          viol = 1'b1;
        else if (done)                nxt  = S_SLEEP;
      default:                        nxt  = S_GRANT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_GRANT;
      cnt       <= '0;
      proto_err <= 1'b0;
    end else begin
      st <= nxt;
      if (viol) proto_err <= 1'b1;
      if (st != S_RELOCK)  cnt <= '0;
      else if (!done)      cnt <= cnt + 1'b1;
    end

  assign state_o     = st;
  assign vid_o       = (st == S_DEEPER) ? VID_DEEPER :
                       (st == S_ENH)    ? VID_ENH    : VID_NOM;
  assign clk_stop_ok = (st == S_DEEP) || (st == S_DEEPER) || (st == S_ENH);
  assign snoop_en    = (st == S_GRANT) || (st == S_SLEEP);
  assign pll_stable  = snoop_en;
endmodule

// File: rtl/sleep_ladder_chk.sv
module sleep_ladder_chk #(
  parameter logic [6:0] VID_NOM    = 7'h30,
  parameter logic [6:0] VID_DEEPER = 7'h3A,
  parameter logic [6:0] VID_ENH    = 7'h42
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cache_off,
  input logic [2:0] state_o,
  input logic [6:0] vid_o,
  input logic       clk_stop_ok,
  input logic       snoop_en,
  input logic       pll_stable,
  input logic       proto_err
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (state_o == 3'd0 && vid_o == VID_NOM && !proto_err));

  p_deep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |->
      ($past(state_o) == 3'd1 || $past(state_o) == 3'd3 || $past(state_o) == 3'd4));

  p_deep_outputs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |-> (clk_stop_ok && !snoop_en && !pll_stable && vid_o == VID_NOM));

  p_deeper_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2 && !$past(cache_off)));

  p_deeper_vid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3) |-> (vid_o == VID_DEEPER));

  p_enh_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd2 && $past(cache_off)));

  p_enh_vid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> (vid_o == VID_ENH));

  p_relock_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == 3'd5 && state_o == 3'd1) |-> ($past(state_o, 2) == 3'd5));

  p_relock_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5) |-> (!pll_stable && !snoop_en && !clk_stop_ok));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  p_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_en |-> (state_o <= 3'd1));
endmodule

bind sleep_ladder sleep_ladder_chk #(
  .VID_NOM(VID_NOM), .VID_DEEPER(VID_DEEPER), .VID_ENH(VID_ENH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cache_off(cache_off), .state_o(state_o),
  .vid_o(vid_o), .clk_stop_ok(clk_stop_ok), .snoop_en(snoop_en),
  .pll_stable(pll_stable), .proto_err(proto_err)
);

// File: tb/sleep_ladder_bench.sv
module sleep_ladder_bench;
  localparam int CPU = 2;
  localparam int SUS = 15;
  localparam logic [6:0] VN = 7'h30, VD = 7'h3A, VE = 7'h42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sl = 1'b0, dp = 1'b0, dr = 1'b0, cache = 1'b0;
  logic [2:0] state_o;
  logic [6:0] vid_o;
  logic clk_stop_ok, snoop_en, pll_stable, proto_err;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sleep_ladder #(.CYC_PER_US(CPU), .SETTLE_US(SUS), .VID_NOM(VN), .VID_DEEPER(VD), .VID_ENH(VE))
  u_sleep_ladder (
    .clk(clk), .rst_n(rst_n), .sleep_n(~sl), .deep_n(~dp), .deeper_n(~dr),
    .cache_off(cache), .state_o(state_o), .vid_o(vid_o), .clk_stop_ok(clk_stop_ok),
    .snoop_en(snoop_en), .pll_stable(pll_stable), .proto_err(proto_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic a, logic b, logic c, logic k);
    @(negedge clk);
    sl = a; dp = b; dr = c; cache = k;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sl = 0; dp = 0; dr = 0; cache = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic go_to(int s, logic k);
    do_reset();
    if (s >= 1) step(1, 0, 0, 0);
    if (s >= 2) step(1, 1, 0, k);
    if (s >= 3) step(1, 1, 1, k);
  endtask

  function automatic int hold_vec(int s);
    case (s)
      0: return 0;
      1: return 1;
      2: return 3;
      default: return 7;
    endcase
  endfunction

  function automatic int model(int s, int v, bit k);
    bit a = v[0], b = v[1], c = v[2];
    case (s)
      0: if (b || c) return 8 + s; else return a ? 1 : 0;
      1: if (c || (b && !a)) return 8 + s; else if (!a) return 0; else return b ? 2 : 1;
      2: if (!a || (c && !b)) return 8 + s; else if (!b) return 5;
         else if (c) return k ? 4 : 3; else return 2;
      default: if (!a || !b) return 8 + s; else return c ? s : 2;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1 reset values
    check("R1 state", state_o, 0);
    check("R1 vid", vid_o, VN);
    check("R1 snoop_en", snoop_en, 1);
    check("R1 pll_stable", pll_stable, 1);
    check("R1 clk_stop_ok", clk_stop_ok, 0);
    check("R1 proto_err", proto_err, 0);

    // R2 R3 R4 R5 R6 R8 sweep: every rung x every request vector
    for (int s = 0; s < 5; s++) begin
      for (int v = 0; v < 8; v++) begin
        for (int k = 0; k < 2; k++) begin
          int e;
          int hs;
          if (k == 1 && s != 2) continue;
          go_to(s == 4 ? 3 : s, s == 4);
          hs = hold_vec(s);
          step(hs[0], hs[1], hs[2], s == 4 ? 1'b1 : 1'b0);
          e = model(s, v, k[0]);
          step(v[0], v[1], v[2], k[0]);
          check(e >= 8 ? "R8 state held" : "R2 R3 R4 R5 R6 next state", state_o, e % 8);
          check("R8 proto_err", proto_err, e >= 8);
        end
      end
    end

    // R3 outputs in Deep Sleep
    go_to(2, 0);
    check("R3 clk_stop_ok", clk_stop_ok, 1);
    check("R3 snoop_en", snoop_en, 0);
    check("R9 snoop_en off in deep", snoop_en, 0);
    check("R3 pll_stable", pll_stable, 0);

    // R4 code and R6 return code
    go_to(3, 0);
    check("R4 vid", vid_o, VD);
    step(1, 1, 0, 0);
    check("R6 state", state_o, 2);
    check("R6 vid", vid_o, VN);

    // R5 cache flag ignored once in a Deeper variant
    go_to(3, 1);
    check("R5 state", state_o, 4);
    check("R5 vid", vid_o, VE);
    step(1, 1, 1, 0);
    check("R5 cache change ignored state", state_o, 4);
    check("R5 cache change ignored vid", vid_o, VE);
    go_to(3, 0);
    step(1, 1, 1, 1);
    check("R5 cache rise ignored in deeper", state_o, 3);
    check("R5 cache rise ignored vid", vid_o, VD);

    // R7 re-lock duration and outputs
    go_to(2, 0);
    @(negedge clk);
    dp = 0;
    begin
      int n = 0;
      @(negedge clk);
      check("R7 enters relock", state_o, 5);
      check("R7 pll_stable low", pll_stable, 0);
      check("R7 clk_stop_ok low", clk_stop_ok, 0);
      check("R9 snoop_en off in relock", snoop_en, 0);
      while (state_o == 3'd5 && n < 1000) begin
        n++;
        @(negedge clk);
      end
      check("R7 relock length", n, CPU * SUS);
      check("R7 ends in sleep", state_o, 1);
      check("R7 pll_stable restored", pll_stable, 1);
      check("R9 snoop_en in sleep", snoop_en, 1);
    end

    // R8 violation in relock, and stickiness
    go_to(2, 0);
    step(1, 0, 0, 0);
    check("R8 relock entered", state_o, 5);
    step(0, 0, 0, 0);
    check("R8 relock held on violation", state_o, 5);
    check("R8 proto_err set", proto_err, 1);
    step(1, 0, 0, 0);
    repeat (CPU * SUS + 2) @(negedge clk);
    check("R8 relock completes", state_o, 1);
    check("R8 proto_err sticky", proto_err, 1);
    do_reset();
    @(negedge clk);
    check("R1 proto_err cleared by reset", proto_err, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule